// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and an incoming carry with no clock. It splits the operands into four lanes of four bits. In each lane, every bit forms a generate term and a propagate term. A bit generates when both operand bits are high and propagates when exactly one of them is high. From these terms each lane computes its internal carries and a lane-level generate/propagate pair in flattened sum-of-products form.

A second lookahead stage takes the four lane pairs and the incoming carry and computes the carry into every lane at once. No carry passes serially from one lane to the next. The block also reports its whole-word generate and propagate terms. A wider adder can therefore treat this block as one lane of a further lookahead level. Lane width and lane count are parameters, and the defaults give 16 bits.

Top module: `cla_adder`

## Requirements
- R1: `sumOut` equals the low 16 bits of `opA + opB + carryIn` for every input combination.
- R2: `carryOut` equals bit 16 of the 17-bit value `opA + opB + carryIn`.
- R3: `blkProp` is 1 exactly when every bit position has one operand bit set and the other clear, meaning `opA ^ opB` is all ones.
- R4: `blkGen` is 1 exactly when `opA + opB`, without the incoming carry, carries out of bit 15.
- R5: `carryOut` always equals `blkGen | (blkProp & carryIn)`.
- R6: An incoming carry crosses all four lanes in one evaluation. With `opA = 16'hFFFF`, `opB = 16'h0000` and `carryIn = 1`, the result is `sumOut = 0` and `carryOut = 1`.
- R7: Lanes are classified like single bits. A lane holding 0001+1111 in bits 3:0 sends a carry into bit 4 whatever the value of `carryIn`. A lane holding 0000+1111 sends a carry into bit 4 only when `carryIn` is 1.
- R8: The outputs depend only on the present inputs. All-zero inputs give `sumOut = 0`, `carryOut = 0`, `blkProp = 0` and `blkGen = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Incoming carry into bit 0 |
| sumOut | output | 16 | Low 16 bits of the sum |
| carryOut | output | 1 | Carry out of bit 15 |
| blkProp | output | 1 | Whole-word propagate, for a further lookahead level |
| blkGen | output | 1 | Whole-word generate, for a further lookahead level |

## Verification
Every result is due in the same cycle as its stimulus, because the block holds no register. The bench drives each operand set 1 ns after a rising edge and compares all four outputs at the following falling edge. That leaves the adder 3 ns to settle before the comparison. The bench compares against a behavioural integer model on every clock while a vector is applied. Directed vectors aimed at R6, R7 and R8 run first, then pseudo-random vectors follow.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;
  // Generate/propagate pair handed from a lane to the next lookahead level
  typedef struct packed {
    logic gen;
    logic prop;
  } pgPair_t;
endpackage

// File: rtl/cla_lookahead.sv
`timescale 1ns/1ps
// Flattened two-level lookahead over N generate/propagate pairs.
// carries[i] is the carry into position i; carries[N] leaves the top.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] genIn,
  input  logic [N-1:0] propIn,
  input  logic         carryIn,
  output logic [N:0]   carries,
  output logic         blkGen,
  output logic         blkProp
);
  always_comb begin
    for (int i = 0; i <= N; i++) begin
      logic acc;
      logic term;
      // incoming-carry product term
      acc = carryIn;
      for (int k = 0; k < i; k++) acc = acc & propIn[k];
      // one product term per lower generate
      for (int j = 0; j < i; j++) begin
        term = genIn[j];
        for (int k = j + 1; k < i; k++) term = term & propIn[k];
        acc = acc | term;
      end
      carries[i] = acc;
    end
  end

  always_comb begin
    logic grp;
    logic term;
    grp = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = genIn[j];
      for (int k = j + 1; k < N; k++) term = term & propIn[k];
      grp = grp | term;
    end
    blkGen  = grp;
    blkProp = &propIn;
  end
endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
// One lane: bit terms, local lookahead, sum bits and lane pair.
module cla_group
  import cla_pkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] laneA,
  input  logic [GROUP_W-1:0] laneB,
  input  logic               laneCarry,
  output logic [GROUP_W-1:0] laneSum,
  output pgPair_t            lanePg
);
  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W:0]   bitCarry;
  logic               laneGen;
  logic               laneProp;
  logic               unusedTopCarry;

  assign bitGen  = laneA & laneB;
  assign bitProp = laneA ^ laneB;

  cla_lookahead #(.N(GROUP_W)) bitLa_i (
    .genIn   (bitGen),
    .propIn  (bitProp),
    .carryIn (laneCarry),
    .carries (bitCarry),
    .blkGen  (laneGen),
    .blkProp (laneProp)
  );

  assign laneSum        = bitProp ^ bitCarry[GROUP_W-1:0];
  assign lanePg.gen     = laneGen;
  assign lanePg.prop    = laneProp;
  assign unusedTopCarry = bitCarry[GROUP_W];
endmodule

// File: rtl/cla_adder.sv
`timescale 1ns/1ps
// Thin top: lanes feed a second lookahead level that carries into each lane.
module cla_adder
  import cla_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             blkProp,
  output logic             blkGen
);
  pgPair_t [NUM_GROUPS-1:0] lanePg;
  logic [NUM_GROUPS-1:0]    laneGenVec;
  logic [NUM_GROUPS-1:0]    lanePropVec;
  logic [NUM_GROUPS:0]      laneCarry;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gLane
    cla_group #(.GROUP_W(GROUP_W)) lane_i (
      .laneA     (opA[g*GROUP_W +: GROUP_W]),
      .laneB     (opB[g*GROUP_W +: GROUP_W]),
      .laneCarry (laneCarry[g]),
      .laneSum   (sumOut[g*GROUP_W +: GROUP_W]),
      .lanePg    (lanePg[g])
    );
    assign laneGenVec[g]  = lanePg[g].gen;
    assign lanePropVec[g] = lanePg[g].prop;
  end

  cla_lookahead #(.N(NUM_GROUPS)) laneLa_i (
    .genIn   (laneGenVec),
    .propIn  (lanePropVec),
    .carryIn (carryIn),
    .carries (laneCarry),
    .blkGen  (blkGen),
    .blkProp (blkProp)
  );

  assign carryOut = laneCarry[NUM_GROUPS];
endmodule

// File: rtl/cla_adder_chk.sv
`timescale 1ns/1ps
// Port-level checker bound to the adder.
module cla_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic             blkProp,
  input logic             blkGen
);
  logic [WIDTH:0] fullSum;
  logic [WIDTH:0] plainSum;

  always_comb begin
    fullSum  = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    plainSum = {1'b0, opA} + {1'b0, opB};
  end

  always_comb begin
    a_r1_sum_value:    assert (sumOut == fullSum[WIDTH-1:0]);
    a_r2_carry_value:  assert (carryOut == fullSum[WIDTH]);
    a_r3_word_prop:    assert (blkProp == ((opA ^ opB) == {WIDTH{1'b1}}));
    a_r4_word_gen:     assert (blkGen == plainSum[WIDTH]);
    a_r5_cascade_form: assert (carryOut == (blkGen | (blkProp & carryIn)));
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut),
  .blkProp  (blkProp),
  .blkGen   (blkGen)
);

// File: tb/cla_adder_tb_top.sv
`timescale 1ns/1ps
module cla_adder_tb_top;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
    string        tag;
  } vec_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;
  logic         blkProp;
  logic         blkGen;
  string        curTag = "R8";
  bit           active = 1'b0;
  int           checks = 0;
  int           failures = 0;
  vec_t         vq[$];

  always #4 clk = ~clk; // 125 MHz

  cla_adder dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut), .blkProp(blkProp), .blkGen(blkGen)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (%s) a=%h b=%h cin=%0d actual=%0h expected=%0h",
               req, curTag, opA, opB, carryIn, act, exp);
    end
  endtask

  // Behavioural reference, compared every falling edge while stimulus is live
  always @(negedge clk) begin
    if (!rst && active) begin
      int full;
      int plain;
      full  = int'(opA) + int'(opB) + int'(carryIn);
      plain = int'(opA) + int'(opB);
      check("R1", longint'(sumOut), longint'(full % 65536));
      check("R2", longint'(carryOut), longint'(full / 65536));
      check("R3", longint'(blkProp), longint'((opA ^ opB) == 16'hFFFF));
      check("R4", longint'(blkGen), longint'(plain / 65536));
      check("R5", longint'(carryOut), longint'(blkGen | (blkProp & carryIn)));
    end
  end

  task automatic addVec(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input string tag);
    vec_t v;
    v.a = a; v.b = b; v.c = c; v.tag = tag;
    vq.push_back(v);
  endtask

  initial begin
    // R8: zero inputs
    addVec(16'h0000, 16'h0000, 1'b0, "R8");
    // R6: carry through every lane
    addVec(16'hFFFF, 16'h0000, 1'b1, "R6");
    addVec(16'h5555, 16'hAAAA, 1'b1, "R6");
    addVec(16'h5555, 16'hAAAA, 1'b0, "R3");
    addVec(16'hFFFF, 16'hFFFF, 1'b1, "R4");
    addVec(16'h8000, 16'h8000, 1'b0, "R4");
    // R7: lane classification in bits 3:0
    addVec(16'h0001, 16'h000F, 1'b0, "R7");
    addVec(16'h0001, 16'h000F, 1'b1, "R7");
    addVec(16'h0000, 16'h000F, 1'b0, "R7");
    addVec(16'h0000, 16'h000F, 1'b1, "R7");
    addVec(16'h0F00, 16'h00F0, 1'b1, "R6");
    for (int i = 0; i < 3000; i++)
      addVec(W'($urandom), W'($urandom), 1'($urandom), "rand");

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    foreach (vq[i]) begin
      @(posedge clk);
      #1;
      opA = vq[i].a; opB = vq[i].b; carryIn = vq[i].c; curTag = vq[i].tag;
      active = 1'b1;
    end
    @(posedge clk);
    #1 active = 1'b0;
    // R7 bit 4 observed directly on the sum
    opA = 16'h0000; opB = 16'h000F; carryIn = 1'b0; curTag = "R7";
    #2 check("R7", longint'(sumOut[4]), 0);
    carryIn = 1'b1;
    #2 check("R7", longint'(sumOut[4]), 1);
    opA = 16'h0001; carryIn = 1'b0;
    #2 check("R7", longint'(sumOut[4]), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule